// File: doc/BRIEF.md
# Parity-Protected Registered/Latched Bus Transceiver

This block links an A side and a B side with a 16-bit data path in each direction. The data travels as two bytes, and each byte has its own parity bit beside it. Each direction has three controls: an active-low output enable, a latch enable and a capture strobe. When the latch enable is high, the direction is transparent. When it is low, the direction holds a stored word and loads a new one only on a rising edge of its strobe. Both parity bits go through the same storage stage as their bytes, so data and parity stay aligned.

A mode input chooses between generating parity and checking it, and a second input chooses odd or even parity. Only the A-to-B direction can generate parity. The B-to-A direction always checks, so it can check while A-to-B is generating. Each receiving side has its own active-low error flag. The flag merges the errors from both bytes and is computed from the word the side is currently presenting. Tri-state drive is shown as a data output plus a drive-enable output.

The strobes are ordinary inputs sampled by the system clock. A strobe edge is recognised when a clock edge sees the strobe high after it was low at the previous clock edge.

Top module: `tcv_top`

## Requirements
- R1: When a side's output enable (`ab_oe_n` for B, `ba_oe_n` for A) is high, that side's drive output is 0 and its error flag is 1. When the enable is low, the drive output is 1.
- R2: When a direction's latch enable is high, its data and parity outputs follow its inputs combinationally, with no clock needed.
- R3: When the latch enable is low, the stored word is loaded at a clock edge that sees the strobe high after it was low at the previous clock edge. The output shows the new word after that clock edge. A strobe that stays high loads nothing more.
- R4: When the latch enable is low and no strobe rising edge is seen, the output keeps its previous value even if the inputs change.
- R5: In generate mode (`chk_mode`=0), the B-side parity bit k is the XOR of data bits [8k+7:8k] XOR `odd_sel`. Byte 0 (bits 7:0) maps to parity bit 0 and byte 1 (bits 15:8) maps to parity bit 1. With `odd_sel`=0 this gives even parity over nine bits; with `odd_sel`=1 it gives odd parity.
- R6: In check mode (`chk_mode`=1), a byte is in error when the XOR of its eight data bits and its parity bit, XOR `odd_sel`, is 1. The B-side flag is low when either byte is in error.
- R7: In check mode, the received parity bits reach the output unchanged, whether or not an error is found.
- R8: In generate mode, `b_err_n` stays 1.
- R9: The B-to-A direction never generates parity. It forwards `b_par_in` and drives `a_err_n` using the R6 rule in both modes.
- R10: A synchronous reset clears both stored words and their parity bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_mode | input | 1 | 1 = check parity, 0 = generate parity (A-to-B only) |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| ab_oe_n | input | 1 | B-side output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cke | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | A-side output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cke | input | 1 | B-to-A capture strobe |
| a_data_in | input | 16 | Data arriving from the A side |
| a_par_in | input | 2 | Parity arriving from the A side |
| b_data_in | input | 16 | Data arriving from the B side |
| b_par_in | input | 2 | Parity arriving from the B side |
| b_data_out | output | 16 | Data presented to the B side |
| b_par_out | output | 2 | Parity presented to the B side |
| b_drive | output | 1 | B-side drive enable |
| b_err_n | output | 1 | B-side merged parity error flag, active low |
| a_data_out | output | 16 | Data presented to the A side |
| a_par_out | output | 2 | Parity presented to the A side |
| a_drive | output | 1 | A-side drive enable |
| a_err_n | output | 1 | A-side merged parity error flag, active low |

## Verification
The assertions check on every clock that a disabled side never reports an error, and that generate mode keeps the B flag high. They also check that transparent paths follow their inputs, that check-mode parity passes through unchanged, that B-to-A never substitutes generated parity, and that a held direction with no strobe keeps its word. Only the bench scenarios can show the actual parity values and the error decisions for specific data patterns across both parity senses. The same holds for the exact clock at which a strobe edge lands a word, for a strobe held high loading nothing more, and for the reset contents.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        PAR_GEN = 1'b0,
        PAR_CHK = 1'b1
    } par_mode_e;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic cke;
    } dir_ctl_t;

    function automatic logic fold_xor(input logic [BYTE_W-1:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction
endpackage

// File: rtl/tcv_parity.sv
module tcv_parity
    import tcv_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic              par_in,
    input  logic              gen,
    input  logic              odd_sel,
    output logic              par_out,
    output logic              err
);
    logic gen_bit;

    always_comb begin
        gen_bit = fold_xor(data, odd_sel);
        par_out = gen ? gen_bit : par_in;
        err     = gen ? 1'b0 : (gen_bit ^ par_in);
    end
endmodule

// File: rtl/tcv_dir.sv
module tcv_dir
    import tcv_pkg::*;
#(
    parameter int NBYTES  = 2,
    parameter bit CAN_GEN = 1'b1,
    localparam int DW     = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dir_ctl_t          ctl,
    input  logic              gen_req,
    input  logic              odd_sel,
    input  logic [DW-1:0]     d_in,
    input  logic [NBYTES-1:0] p_in,
    output logic [DW-1:0]     d_out,
    output logic [NBYTES-1:0] p_out,
    output logic              drive,
    output logic              err_n
);
    logic [DW-1:0]     d_q;
    logic [NBYTES-1:0] p_q;
    logic              cke_q;
    logic              load;
    logic              gen;
    logic [DW-1:0]     view_d;
    logic [NBYTES-1:0] view_p;
    logic [NBYTES-1:0] byte_err;

    assign load = ctl.le | (ctl.cke & ~cke_q);
    assign gen  = CAN_GEN & gen_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q   <= '0;
            p_q   <= '0;
            cke_q <= 1'b0;
        end else begin
            cke_q <= ctl.cke;
            if (load) begin
                d_q <= d_in;
                p_q <= p_in;
            end
        end
    end

    assign view_d = ctl.le ? d_in : d_q;
    assign view_p = ctl.le ? p_in : p_q;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        tcv_parity u_par (
            .data    (view_d[k*BYTE_W +: BYTE_W]),
            .par_in  (view_p[k]),
            .gen     (gen),
            .odd_sel (odd_sel),
            .par_out (p_out[k]),
            .err     (byte_err[k])
        );
    end

    assign d_out = view_d;
    assign drive = ~ctl.oe_n;
    assign err_n = ctl.oe_n | ~(|byte_err);
endmodule

// File: rtl/tcv_top.sv
module tcv_top
    import tcv_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_mode,
    input  logic              odd_sel,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_cke,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_cke,
    input  logic [DW-1:0]     a_data_in,
    input  logic [NBYTES-1:0] a_par_in,
    input  logic [DW-1:0]     b_data_in,
    input  logic [NBYTES-1:0] b_par_in,
    output logic [DW-1:0]     b_data_out,
    output logic [NBYTES-1:0] b_par_out,
    output logic              b_drive,
    output logic              b_err_n,
    output logic [DW-1:0]     a_data_out,
    output logic [NBYTES-1:0] a_par_out,
    output logic              a_drive,
    output logic              a_err_n
);
    par_mode_e mode;
    dir_ctl_t  ctl_ab;
    dir_ctl_t  ctl_ba;
    logic      gen_req;

    assign mode    = par_mode_e'(chk_mode);
    assign gen_req = (mode == PAR_GEN);
    assign ctl_ab  = '{oe_n: ab_oe_n, le: ab_le, cke: ab_cke};
    assign ctl_ba  = '{oe_n: ba_oe_n, le: ba_le, cke: ba_cke};

    tcv_dir #(.NBYTES(NBYTES), .CAN_GEN(1'b1)) u_ab (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl_ab),
        .gen_req (gen_req),
        .odd_sel (odd_sel),
        .d_in    (a_data_in),
        .p_in    (a_par_in),
        .d_out   (b_data_out),
        .p_out   (b_par_out),
        .drive   (b_drive),
        .err_n   (b_err_n)
    );

    tcv_dir #(.NBYTES(NBYTES), .CAN_GEN(1'b0)) u_ba (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl_ba),
        .gen_req (gen_req),
        .odd_sel (odd_sel),
        .d_in    (b_data_in),
        .p_in    (b_par_in),
        .d_out   (a_data_out),
        .p_out   (a_par_out),
        .drive   (a_drive),
        .err_n   (a_err_n)
    );
endmodule

// File: rtl/tcv_checker.sv
module tcv_checker #(
    parameter int NBYTES = 2,
    localparam int DW    = NBYTES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              chk_mode,
    input logic              ab_oe_n,
    input logic              ab_le,
    input logic              ab_cke,
    input logic              ba_oe_n,
    input logic              ba_le,
    input logic [DW-1:0]     a_data_in,
    input logic [NBYTES-1:0] a_par_in,
    input logic [NBYTES-1:0] b_par_in,
    input logic [DW-1:0]     b_data_out,
    input logic [NBYTES-1:0] b_par_out,
    input logic              b_err_n,
    input logic [NBYTES-1:0] a_par_out,
    input logic              a_err_n
);
    assert_b_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> b_err_n);

    assert_a_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> a_err_n);

    assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> (b_data_out == a_data_in));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !ab_cke) |=> (ab_le || $stable(b_data_out)));

    assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (chk_mode && ab_le) |-> (b_par_out == a_par_in));

    assert_gen_flag_R8: assert property (@(posedge clk) disable iff (rst)
        !chk_mode |-> b_err_n);

    assert_ba_nogen_R9: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> (a_par_out == b_par_in));
endmodule

bind tcv_top tcv_checker #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/tcv_top_tb.sv
module tcv_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        chk_mode, odd_sel;
    logic        ab_oe_n, ab_le, ab_cke, ba_oe_n, ba_le, ba_cke;
    logic [15:0] a_data_in, b_data_in;
    logic [1:0]  a_par_in, b_par_in;
    logic [15:0] b_data_out, a_data_out;
    logic [1:0]  b_par_out, a_par_out;
    logic        b_drive, b_err_n, a_drive, a_err_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tcv_top u_dut (
        .clk(clk), .rst(rst), .chk_mode(chk_mode), .odd_sel(odd_sel),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cke(ab_cke),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cke(ba_cke),
        .a_data_in(a_data_in), .a_par_in(a_par_in),
        .b_data_in(b_data_in), .b_par_in(b_par_in),
        .b_data_out(b_data_out), .b_par_out(b_par_out),
        .b_drive(b_drive), .b_err_n(b_err_n),
        .a_data_out(a_data_out), .a_par_out(a_par_out),
        .a_drive(a_drive), .a_err_n(a_err_n)
    );

    typedef struct packed {
        logic        chk;
        logic        odd;
        logic [15:0] data;
        logic [1:0]  par;
        logic [1:0]  exp_par;
        logic        exp_err_n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 2'b00, 2'b00, 1'b1},
        '{1'b0, 1'b0, 16'h0301, 2'b11, 2'b01, 1'b1},
        '{1'b0, 1'b1, 16'h0301, 2'b00, 2'b10, 1'b1},
        '{1'b0, 1'b1, 16'hFF7F, 2'b00, 2'b10, 1'b1},
        '{1'b1, 1'b0, 16'h0301, 2'b01, 2'b01, 1'b1},
        '{1'b1, 1'b0, 16'h0301, 2'b00, 2'b00, 1'b0},
        '{1'b1, 1'b1, 16'h0301, 2'b10, 2'b10, 1'b1},
        '{1'b1, 1'b1, 16'h0000, 2'b00, 2'b00, 1'b0},
        '{1'b1, 1'b0, 16'hFF00, 2'b10, 2'b10, 1'b0},
        '{1'b1, 1'b1, 16'h8001, 2'b11, 2'b11, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R) actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; chk_mode = 1'b1; odd_sel = 1'b0;
        ab_oe_n = 1'b0; ab_le = 1'b0; ab_cke = 1'b0;
        ba_oe_n = 1'b0; ba_le = 1'b0; ba_cke = 1'b0;
        a_data_in = 16'hA5A5; a_par_in = 2'b11;
        b_data_in = 16'h5A5A; b_par_in = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R10: reset clears the stored words
        check("R10 b data after reset", b_data_out, 16'h0000);
        check("R10 b parity after reset", b_par_out, 2'b00);
        check("R10 a data after reset", a_data_out, 16'h0000);
        check("R10 b flag after reset (0 data, 0 parity, even)", b_err_n, 1'b1);
        check("R1 b drive on", b_drive, 1'b1);

        // Vector table: A-to-B transparent (R2, R5, R6, R7, R8)
        ab_le = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk_mode = VEC[i].chk; odd_sel = VEC[i].odd;
            a_data_in = VEC[i].data; a_par_in = VEC[i].par;
            #1;
            check("R2 transparent data", b_data_out, VEC[i].data);
            check(VEC[i].chk ? "R7 parity passthrough" : "R5 generated parity",
                  b_par_out, VEC[i].exp_par);
            check(VEC[i].chk ? "R6 check flag" : "R8 flag high in generate",
                  b_err_n, VEC[i].exp_err_n);
        end

        // R1: output enable high forces flag high and drive off
        @(negedge clk);
        chk_mode = 1'b1; odd_sel = 1'b0; a_data_in = 16'h0001; a_par_in = 2'b00;
        #1 check("R6 error before disable", b_err_n, 1'b0);
        ab_oe_n = 1'b1;
        #1 check("R1 drive off", b_drive, 1'b0);
        check("R1 flag forced high", b_err_n, 1'b1);
        ab_oe_n = 1'b0;

        // R3: capture on strobe rising edge
        @(negedge clk);
        ab_le = 1'b0; a_data_in = 16'h1234; a_par_in = 2'b10;
        @(negedge clk);
        check("R4 held last transparent word", b_data_out, 16'h0001);
        ab_cke = 1'b1;
        #1 check("R3 no change before clock edge", b_data_out, 16'h0001);
        @(negedge clk);
        check("R3 word captured", b_data_out, 16'h1234);
        check("R3 parity captured", b_par_out, 2'b10);
        a_data_in = 16'hBEEF;
        repeat (2) @(negedge clk);
        check("R3 held strobe loads nothing", b_data_out, 16'h1234);
        ab_cke = 1'b0; a_data_in = 16'hCAFE;
        repeat (2) @(negedge clk);
        check("R4 hold with strobe low", b_data_out, 16'h1234);
        ab_cke = 1'b1;
        @(negedge clk);
        check("R3 second edge captures", b_data_out, 16'hCAFE);
        ab_cke = 1'b0;

        // R9: B-to-A checks in generate mode, never generates
        @(negedge clk);
        chk_mode = 1'b0; odd_sel = 1'b0; ba_le = 1'b1;
        b_data_in = 16'h0001; b_par_in = 2'b00;
        #1 check("R9 a parity not generated", a_par_out, 2'b00);
        check("R9 a flag checks in generate mode", a_err_n, 1'b0);
        check("R8 b flag high in generate", b_err_n, 1'b1);
        b_par_in = 2'b01;
        #1 check("R9 a flag clean", a_err_n, 1'b1);
        ba_oe_n = 1'b1; b_par_in = 2'b00;
        #1 check("R1 a flag forced high", a_err_n, 1'b1);
        check("R1 a drive off", a_drive, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule